// File: doc/BRIEF.md
# Copy Engine Ring Index and Interrupt Controller

This block is the control plane of one copy engine. The engine moves buffers from a ring of source descriptors to a ring of destination descriptors. Software programs both rings through a 32-bit register port. It sets each ring's base and entry count, then advances a software write index for each ring. The block tracks the matching hardware read index and advances it when the stubbed datapath reports a finished descriptor. All index arithmetic is modular over a power-of-two ring size.

From the distance between the indices the block derives several events: ring watermark crossings, overflow of a write-index update, and copy completion. These events are gathered into write-one-to-clear status registers, one for host events and one for errors. Each status register has an enable mask and an interrupt output. A halt command stops completions from being accepted. The halt status appears only once the datapath reports that nothing is in flight.

Top module: `ce_ring_ctrl`

## Requirements
- R1: After reset every register reads 0, both interrupt outputs are low and `src_work` is low.
- R2: The control register at 0x10 stores bits 18:0 of a write and reads bits 31:19 as 0. Bits 15:0 drive `dst_max_len`, bit 16 drives `src_swap_en` and bit 17 drives `dst_swap_en`.
- R3: The ring base registers (source 0x00, destination 0x08) read their low three bits as 0.
- R4: The size registers (0x04, 0x0C) hold the entry count N, a power of two, in bits IDX_W:0. A value of 0 means 2^IDX_W. A write to a write index (source 0x3C, destination 0x40) stores the value AND (N−1). Each accepted completion moves the read index (source 0x44, destination 0x48) to (idx+1) AND (N−1). Writes to the read-index offsets have no effect.
- R5: A completion pulse (`src_done` or `dst_done`) is ignored while its ring has no pending entries, where pending = (write − read) AND (N−1). The read index therefore never passes the write index.
- R6: On the source ring, consider a write-index write whose forward distance (new − write) AND (N−1) exceeds the free space (N−1) − pending. Such a write leaves the write index unchanged and sets error status bit 5.
- R7: The same rule applies on the destination ring and sets error status bit 6.
- R8: Each accepted completion sets host status bit 0. `irq_host` is high when any bit of (host status AND host enable at 0x2C bits 4:0) is set.
- R9: Watermark register bits 31:16 hold the low threshold and bits 15:0 the high threshold; the source register is at 0x4C and the destination register at 0x50. One cycle after pending rises from at most high to above high, the ring's high bit sets (host status bit 1 for source, bit 3 for destination). One cycle after pending falls from at least low to below low, the low bit sets (bit 2 for source, bit 4 for destination).
- R10: Host status (0x30) and error status (0x38) clear the bits written as 1. A bit being set in the same cycle stays set.
- R11: `err_evt` bits 0..3 set error status bits 7..10. `irq_err` is high when any bit of (error status AND error enable at 0x34 bits 10:5) is set.
- R12: Command bit 0 at 0x18 is a halt request. Read-only bit 3 becomes 1 on the cycle after the request is seen while `xfer_busy` is low. It stays 0 while `xfer_busy` is high, and it returns to 0 one cycle after the request is cleared.
- R13: While halted, completions are ignored and `src_work` is low. Otherwise `src_work` is high whenever the source ring has pending entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe for the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_done | input | 1 | Datapath finished one source descriptor |
| dst_done | input | 1 | Datapath filled one destination descriptor |
| xfer_busy | input | 1 | A transfer is in flight in the datapath |
| err_evt | input | 4 | Error pulses: dst max length, src length, dst address, bus |
| src_work | output | 1 | Source descriptors are pending and the engine is not halted |
| dst_max_len | output | 16 | Maximum destination length from control |
| src_swap_en | output | 1 | Source byte-swap enable from control |
| dst_swap_en | output | 1 | Destination byte-swap enable from control |
| irq_host | output | 1 | Copy-complete and watermark interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench targets ring wrap-around. A write index that goes below its old value but is still a legal forward step must be accepted. A design that compared indices without the modulus would flag it as overflow or compute a huge pending count. An overflow that exceeds the free space by exactly one entry is driven, as are completions on an empty ring. A read index that ran past the write index would turn a ring that should be empty into one that appears full.

Watermarks are crossed in both directions and then held on one side. A level-sensitive design would re-raise a bit right after software cleared it. Clears are issued in the same cycle as a new event to catch a clear that wins over the set. A halt is requested while `xfer_busy` is high: a design that ignores busy would report halted too early and would keep accepting completions.

// File: rtl/ce_pkg.sv
// Package: register offsets and status bit positions shared by the
// copy engine ring controller and its sub-blocks.
package ce_pkg;
    localparam int unsigned REG_AW = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [REG_AW-1:0] OFS_SRC_BASE = 8'h00;
    localparam logic [REG_AW-1:0] OFS_SRC_SIZE = 8'h04;
    localparam logic [REG_AW-1:0] OFS_DST_BASE = 8'h08;
    localparam logic [REG_AW-1:0] OFS_DST_SIZE = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_CTRL     = 8'h10;
    localparam logic [REG_AW-1:0] OFS_CMD      = 8'h18;
    localparam logic [REG_AW-1:0] OFS_HOST_EN  = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_HOST_ST  = 8'h30;
    localparam logic [REG_AW-1:0] OFS_ERR_EN   = 8'h34;
    localparam logic [REG_AW-1:0] OFS_ERR_ST   = 8'h38;
    localparam logic [REG_AW-1:0] OFS_SRC_WIDX = 8'h3C;
    localparam logic [REG_AW-1:0] OFS_DST_WIDX = 8'h40;
    localparam logic [REG_AW-1:0] OFS_SRC_RIDX = 8'h44;
    localparam logic [REG_AW-1:0] OFS_DST_RIDX = 8'h48;
    localparam logic [REG_AW-1:0] OFS_SRC_WM   = 8'h4C;
    localparam logic [REG_AW-1:0] OFS_DST_WM   = 8'h50;

    // control register field layout
    localparam int unsigned CTRL_W       = 19;
    localparam int unsigned CTRL_LEN_W   = 16;
    localparam int unsigned CTRL_SSWAP   = 16;
    localparam int unsigned CTRL_DSWAP   = 17;

    // command register bits
    localparam int unsigned CMD_REQ_BIT  = 0;
    localparam int unsigned CMD_DONE_BIT = 3;

    // host status bits
    localparam int unsigned HOST_W       = 5;
    localparam int unsigned HB_COPY      = 0;
    localparam int unsigned HB_SRC_HI    = 1;
    localparam int unsigned HB_SRC_LO    = 2;
    localparam int unsigned HB_DST_HI    = 3;
    localparam int unsigned HB_DST_LO    = 4;

    // error status bits, stored from bit ERR_LSB upward
    localparam int unsigned ERR_LSB      = 5;
    localparam int unsigned ERR_W        = 6;
    localparam int unsigned EXT_ERR_W    = 4;

    localparam int unsigned WM_FIELD_W   = 16;
    localparam int unsigned BASE_ALIGN_B = 3;
endpackage

// File: rtl/ce_ring_ptr.sv
// Module: one descriptor ring's index tracker.
// Holds entry count, software write index, hardware read index and the
// watermark thresholds. Derives pending count, overflow of a write-index
// update, accepted completions and watermark crossings.
// Assumes the entry count is a power of two (0 encodes 2^IDX_W) and that
// IDX_W does not exceed WM_W.
module ce_ring_ptr #(
    parameter int IDX_W = 8,
    parameter int WM_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               size_we,
    input  logic [IDX_W:0]     size_wdata,
    input  logic               widx_we,
    input  logic [IDX_W-1:0]   widx_wdata,
    input  logic               wm_we,
    input  logic [2*WM_W-1:0]  wm_wdata,
    input  logic               done_in,
    input  logic               accept_en,
    output logic [IDX_W:0]     size_q,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [IDX_W-1:0]   pending,
    output logic [2*WM_W-1:0]  wm_q,
    output logic               ovf_evt,
    output logic               adv,
    output logic               hi_evt,
    output logic               lo_evt
);
    localparam logic [IDX_W-1:0] ONE = 1;
    localparam logic [IDX_W:0]   ONE_W = 1;

    logic [IDX_W:0]   size_m1;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] room;
    logic [IDX_W-1:0] pend_q;
    logic [31:0]      p_now, p_prev, thr_hi, thr_lo;

    // ring arithmetic: mask, pending distance, free room and requested step
    always_comb begin
        size_m1 = size_q - ONE_W;
        mask    = size_m1[IDX_W-1:0];
        pending = (wr_idx - rd_idx) & mask;
        room    = mask - pending;
        req_idx = widx_wdata & mask;
        step    = (req_idx - wr_idx) & mask;
        ovf_evt = widx_we && (step > room);
        adv     = done_in && accept_en && (pending != '0);
    end

    // watermark crossing detection against the previous cycle's pending count
    always_comb begin
        p_now  = 32'(pending);
        p_prev = 32'(pend_q);
        thr_hi = 32'(wm_q[WM_W-1:0]);
        thr_lo = 32'(wm_q[2*WM_W-1:WM_W]);
        hi_evt = (p_now > thr_hi) && (p_prev <= thr_hi);
        lo_evt = (p_now < thr_lo) && (p_prev >= thr_lo);
    end

    // configuration registers: entry count and thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            wm_q   <= '0;
        end else begin
            if (size_we) size_q <= size_wdata;
            if (wm_we)   wm_q   <= wm_wdata;
        end
    end

    // software write index, updated only by a write that fits
    always_ff @(posedge clk) begin
        if (!rst_n)                    wr_idx <= '0;
        else if (widx_we && !ovf_evt)  wr_idx <= req_idx;
    end

    // hardware read index, advanced by each accepted completion
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_idx <= '0;
        else if (adv) rd_idx <= (rd_idx + ONE) & mask;
    end

    // delayed pending count for edge detection of watermark crossings
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pending;
    end

    // R4: read index moves by exactly one modular step per completion
    assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> rd_idx == (($past(rd_idx) + ONE) & $past(mask)));

    // R5: an empty ring keeps its read index
    assert_no_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0 && !widx_we && !size_we) |=> $stable(rd_idx));

    // R6: a rejected write leaves the write index alone
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> $stable(wr_idx));
endmodule

// File: rtl/ce_halt_ctrl.sv
// Module: halt handshake.
// Holds the halt request and raises the halted flag once the request is
// present and the datapath reports no transfer in flight; the flag drops
// one cycle after the request is withdrawn.
module ce_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_we,
    input  logic req_wdata,
    input  logic busy,
    output logic halt_req_q,
    output logic halted_q
);
    // request register written by software
    always_ff @(posedge clk) begin
        if (!rst_n)      halt_req_q <= 1'b0;
        else if (req_we) halt_req_q <= req_wdata;
    end

    // halted flag: waits for an idle datapath, holds while requested
    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else        halted_q <= halt_req_q && (halted_q || !busy);
    end

    // R12: no request, no halt on the next cycle
    assert_halt_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req_q |=> !halted_q);

    // R12: a busy datapath keeps an unhalted engine running
    assert_halt_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !halted_q) |=> !halted_q);
endmodule

// File: rtl/ce_w1c_bank.sv
// Module: sticky status bank with enable mask.
// Each status bit sets on its event and clears when written with 1;
// an event in the same cycle wins. The interrupt is the OR of the
// enabled status bits.
module ce_w1c_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] en_q,
    output logic         irq
);
    logic [W-1:0] clr_eff;

    // clear mask applies only on a write to the status offset
    always_comb clr_eff = clr_we ? clr_vec : '0;

    // sticky status with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_eff) | set_vec;
    end

    // enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    assign irq = |(stat_q & en_q);

    // R10: a raised event is visible next cycle whatever was cleared
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    // R10: written ones clear when no event collides
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_vec == '0) |=> ((stat_q & $past(clr_vec)) == '0));
endmodule

// File: rtl/ce_ring_ctrl.sv
// Module: copy engine ring controller top.
// Register port, two ring trackers, halt handshake and two status banks.
// Assumes single-cycle register writes and that the datapath raises
// src_done/dst_done for one cycle per descriptor it finishes.
module ce_ring_ctrl #(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        src_done,
    input  logic        dst_done,
    input  logic        xfer_busy,
    input  logic [3:0]  err_evt,
    output logic        src_work,
    output logic [15:0] dst_max_len,
    output logic        src_swap_en,
    output logic        dst_swap_en,
    output logic        irq_host,
    output logic        irq_err
);
    import ce_pkg::*;

    localparam int WM_W  = WM_FIELD_W;
    localparam int BASE_W = DATA_W - BASE_ALIGN_B;

    logic [BASE_W-1:0] src_base_q, dst_base_q;
    logic [CTRL_W-1:0] ctrl_q;

    logic [IDX_W:0]    s_size, d_size;
    logic [IDX_W-1:0]  s_wr, s_rd, s_pend, d_wr, d_rd, d_pend;
    logic [2*WM_W-1:0] s_wm, d_wm;
    logic              s_ovf, s_adv, s_hi, s_lo;
    logic              d_ovf, d_adv, d_hi, d_lo;
    logic              halt_req, halted;
    logic [HOST_W-1:0] host_set, host_st, host_en;
    logic [ERR_W-1:0]  err_set, err_st, err_en;
    logic              irq_h, irq_e;

    // per-offset write strobes
    logic we_sbase, we_ssize, we_dbase, we_dsize, we_ctrl, we_cmd;
    logic we_hen, we_hst, we_een, we_est, we_swidx, we_dwidx, we_swm, we_dwm;

    // decode a register write into one strobe per offset
    always_comb begin
        we_sbase = reg_we && (reg_addr == OFS_SRC_BASE);
        we_ssize = reg_we && (reg_addr == OFS_SRC_SIZE);
        we_dbase = reg_we && (reg_addr == OFS_DST_BASE);
        we_dsize = reg_we && (reg_addr == OFS_DST_SIZE);
        we_ctrl  = reg_we && (reg_addr == OFS_CTRL);
        we_cmd   = reg_we && (reg_addr == OFS_CMD);
        we_hen   = reg_we && (reg_addr == OFS_HOST_EN);
        we_hst   = reg_we && (reg_addr == OFS_HOST_ST);
        we_een   = reg_we && (reg_addr == OFS_ERR_EN);
        we_est   = reg_we && (reg_addr == OFS_ERR_ST);
        we_swidx = reg_we && (reg_addr == OFS_SRC_WIDX);
        we_dwidx = reg_we && (reg_addr == OFS_DST_WIDX);
        we_swm   = reg_we && (reg_addr == OFS_SRC_WM);
        we_dwm   = reg_we && (reg_addr == OFS_DST_WM);
    end

    // plain configuration registers: bases and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base_q <= '0;
            dst_base_q <= '0;
            ctrl_q     <= '0;
        end else begin
            if (we_sbase) src_base_q <= reg_wdata[DATA_W-1:BASE_ALIGN_B];
            if (we_dbase) dst_base_q <= reg_wdata[DATA_W-1:BASE_ALIGN_B];
            if (we_ctrl)  ctrl_q     <= reg_wdata[CTRL_W-1:0];
        end
    end

    ce_ring_ptr #(.IDX_W(IDX_W), .WM_W(WM_W)) u_src_ring (
        .clk(clk), .rst_n(rst_n),
        .size_we(we_ssize), .size_wdata(reg_wdata[IDX_W:0]),
        .widx_we(we_swidx), .widx_wdata(reg_wdata[IDX_W-1:0]),
        .wm_we(we_swm), .wm_wdata(reg_wdata),
        .done_in(src_done), .accept_en(!halted),
        .size_q(s_size), .wr_idx(s_wr), .rd_idx(s_rd), .pending(s_pend),
        .wm_q(s_wm), .ovf_evt(s_ovf), .adv(s_adv), .hi_evt(s_hi), .lo_evt(s_lo)
    );

    ce_ring_ptr #(.IDX_W(IDX_W), .WM_W(WM_W)) u_dst_ring (
        .clk(clk), .rst_n(rst_n),
        .size_we(we_dsize), .size_wdata(reg_wdata[IDX_W:0]),
        .widx_we(we_dwidx), .widx_wdata(reg_wdata[IDX_W-1:0]),
        .wm_we(we_dwm), .wm_wdata(reg_wdata),
        .done_in(dst_done), .accept_en(!halted),
        .size_q(d_size), .wr_idx(d_wr), .rd_idx(d_rd), .pending(d_pend),
        .wm_q(d_wm), .ovf_evt(d_ovf), .adv(d_adv), .hi_evt(d_hi), .lo_evt(d_lo)
    );

    ce_halt_ctrl u_halt (
        .clk(clk), .rst_n(rst_n),
        .req_we(we_cmd), .req_wdata(reg_wdata[CMD_REQ_BIT]),
        .busy(xfer_busy), .halt_req_q(halt_req), .halted_q(halted)
    );

    // gather host and error events into their status set vectors
    always_comb begin
        host_set            = '0;
        host_set[HB_COPY]   = s_adv || d_adv;
        host_set[HB_SRC_HI] = s_hi;
        host_set[HB_SRC_LO] = s_lo;
        host_set[HB_DST_HI] = d_hi;
        host_set[HB_DST_LO] = d_lo;
        err_set             = {err_evt, d_ovf, s_ovf};
    end

    ce_w1c_bank #(.W(HOST_W)) u_host_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(host_set),
        .clr_we(we_hst), .clr_vec(reg_wdata[HOST_W-1:0]),
        .en_we(we_hen), .en_wdata(reg_wdata[HOST_W-1:0]),
        .stat_q(host_st), .en_q(host_en), .irq(irq_h)
    );

    ce_w1c_bank #(.W(ERR_W)) u_err_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(err_set),
        .clr_we(we_est), .clr_vec(reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
        .en_we(we_een), .en_wdata(reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
        .stat_q(err_st), .en_q(err_en), .irq(irq_e)
    );

    // read multiplexer over all offsets; unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SRC_BASE: reg_rdata = {src_base_q, {BASE_ALIGN_B{1'b0}}};
            OFS_SRC_SIZE: reg_rdata = 32'(s_size);
            OFS_DST_BASE: reg_rdata = {dst_base_q, {BASE_ALIGN_B{1'b0}}};
            OFS_DST_SIZE: reg_rdata = 32'(d_size);
            OFS_CTRL:     reg_rdata = 32'(ctrl_q);
            OFS_CMD: begin
                reg_rdata[CMD_REQ_BIT]  = halt_req;
                reg_rdata[CMD_DONE_BIT] = halted;
            end
            OFS_HOST_EN:  reg_rdata = 32'(host_en);
            OFS_HOST_ST:  reg_rdata = 32'(host_st);
            OFS_ERR_EN:   reg_rdata = 32'(err_en) << ERR_LSB;
            OFS_ERR_ST:   reg_rdata = 32'(err_st) << ERR_LSB;
            OFS_SRC_WIDX: reg_rdata = 32'(s_wr);
            OFS_DST_WIDX: reg_rdata = 32'(d_wr);
            OFS_SRC_RIDX: reg_rdata = 32'(s_rd);
            OFS_DST_RIDX: reg_rdata = 32'(d_rd);
            OFS_SRC_WM:   reg_rdata = s_wm;
            OFS_DST_WM:   reg_rdata = d_wm;
            default:      reg_rdata = '0;
        endcase
    end

    // datapath-facing outputs
    always_comb begin
        src_work    = (s_pend != '0) && !halted;
        dst_max_len = ctrl_q[CTRL_LEN_W-1:0];
        src_swap_en = ctrl_q[CTRL_SSWAP];
        dst_swap_en = ctrl_q[CTRL_DSWAP];
        irq_host    = irq_h;
        irq_err     = irq_e;
    end

    // R13: a halted engine accepts no completion on either ring
    assert_no_accept_halted_R13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(s_adv || d_adv));

    // R8: any accepted completion raises the copy bit next cycle
    assert_copy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_adv || d_adv) |=> host_st[HB_COPY]);
endmodule

// File: tb/test_ce_ring_ctrl.sv
module test_ce_ring_ctrl;
    localparam int IDX_W = 8;
    localparam int IMAX  = (1 << IDX_W) - 1;

    localparam logic [7:0] A_SBASE = 8'h00, A_SSIZE = 8'h04, A_DBASE = 8'h08,
        A_DSIZE = 8'h0C, A_CTRL = 8'h10, A_CMD = 8'h18, A_HEN = 8'h2C,
        A_HST = 8'h30, A_EEN = 8'h34, A_EST = 8'h38, A_SWI = 8'h3C,
        A_DWI = 8'h40, A_SRI = 8'h44, A_DRI = 8'h48, A_SWM = 8'h4C,
        A_DWM = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        src_done = 1'b0, dst_done = 1'b0, xfer_busy = 1'b0;
    logic [3:0]  err_evt = '0;
    logic        src_work, src_swap_en, dst_swap_en, irq_host, irq_err;
    logic [15:0] dst_max_len;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    ce_ring_ctrl #(.IDX_W(IDX_W)) i_ce_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_done(src_done),
        .dst_done(dst_done), .xfer_busy(xfer_busy), .err_evt(err_evt),
        .src_work(src_work), .dst_max_len(dst_max_len),
        .src_swap_en(src_swap_en), .dst_swap_en(dst_swap_en),
        .irq_host(irq_host), .irq_err(irq_err)
    );

    // behavioural reference state
    int m_ssize, m_dsize, m_swr, m_srd, m_dwr, m_drd, m_swm, m_dwm;
    int m_ctrl, m_sbase, m_dbase, m_ist, m_est, m_ie, m_eie;
    int m_hreq, m_halted, m_sprev, m_dprev;

    function automatic int msk(int sz);
        return (sz - 1) & IMAX;
    endfunction

    function automatic int pend(int wr, int rd, int sz);
        return (wr - rd) & msk(sz);
    endfunction

    task automatic model_reset();
        m_ssize = 0; m_dsize = 0; m_swr = 0; m_srd = 0; m_dwr = 0; m_drd = 0;
        m_swm = 0; m_dwm = 0; m_ctrl = 0; m_sbase = 0; m_dbase = 0;
        m_ist = 0; m_est = 0; m_ie = 0; m_eie = 0;
        m_hreq = 0; m_halted = 0; m_sprev = 0; m_dprev = 0;
    endtask

    function automatic int model_rd(logic [7:0] a);
        case (a)
            A_SBASE: return m_sbase & ~7;
            A_SSIZE: return m_ssize;
            A_DBASE: return m_dbase & ~7;
            A_DSIZE: return m_dsize;
            A_CTRL:  return m_ctrl;
            A_CMD:   return m_hreq | (m_halted << 3);
            A_HEN:   return m_ie;
            A_HST:   return m_ist;
            A_EEN:   return m_eie << 5;
            A_EST:   return m_est << 5;
            A_SWI:   return m_swr;
            A_DWI:   return m_dwr;
            A_SRI:   return m_srd;
            A_DRI:   return m_drd;
            A_SWM:   return m_swm;
            A_DWM:   return m_dwm;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            A_CTRL: return "R2";
            A_SBASE, A_DBASE: return "R3";
            A_SSIZE, A_DSIZE, A_SRI, A_DRI: return "R4";
            A_SWI: return "R6";
            A_DWI: return "R7";
            A_HEN: return "R8";
            A_SWM, A_DWM: return "R9";
            A_HST: return "R10";
            A_EEN, A_EST: return "R11";
            A_CMD: return "R12";
            default: return "R1";
        endcase
    endfunction

    // one reference step from the inputs present at the clock edge
    task automatic model_step();
        int ps, pd, sm, dm, req, st, room, ist_n, est_n, wd;
        ps = pend(m_swr, m_srd, m_ssize);
        pd = pend(m_dwr, m_drd, m_dsize);
        sm = msk(m_ssize);
        dm = msk(m_dsize);
        wd = int'(reg_wdata);
        ist_n = 0;
        est_n = int'(err_evt) << 2;
        if (src_done && !m_halted && ps != 0) begin
            m_srd = (m_srd + 1) & sm; ist_n |= 1;
        end
        if (dst_done && !m_halted && pd != 0) begin
            m_drd = (m_drd + 1) & dm; ist_n |= 1;
        end
        if (ps > (m_swm & 16'hFFFF) && m_sprev <= (m_swm & 16'hFFFF)) ist_n |= 2;
        if (ps < ((m_swm >> 16) & 16'hFFFF) && m_sprev >= ((m_swm >> 16) & 16'hFFFF)) ist_n |= 4;
        if (pd > (m_dwm & 16'hFFFF) && m_dprev <= (m_dwm & 16'hFFFF)) ist_n |= 8;
        if (pd < ((m_dwm >> 16) & 16'hFFFF) && m_dprev >= ((m_dwm >> 16) & 16'hFFFF)) ist_n |= 16;
        m_halted = m_hreq & (m_halted | int'(!xfer_busy));
        if (reg_we) begin
            case (reg_addr)
                A_SBASE: m_sbase = wd;
                A_DBASE: m_dbase = wd;
                A_SSIZE: m_ssize = wd & 32'h1FF;
                A_DSIZE: m_dsize = wd & 32'h1FF;
                A_CTRL:  m_ctrl  = wd & 32'h7FFFF;
                A_CMD:   m_hreq  = wd & 1;
                A_HEN:   m_ie    = wd & 32'h1F;
                A_EEN:   m_eie   = (wd >> 5) & 32'h3F;
                A_HST:   m_ist   = m_ist & ~(wd & 32'h1F);
                A_EST:   m_est   = m_est & ~((wd >> 5) & 32'h3F);
                A_SWM:   m_swm   = wd;
                A_DWM:   m_dwm   = wd;
                A_SWI: begin
                    req = wd & sm; st = (req - m_swr) & sm; room = sm - ps;
                    if (st > room) est_n |= 1; else m_swr = req;
                end
                A_DWI: begin
                    req = wd & dm; st = (req - m_dwr) & dm; room = dm - pd;
                    if (st > room) est_n |= 2; else m_dwr = req;
                end
                default: ;
            endcase
        end
        m_ist = m_ist | ist_n;
        m_est = m_est | est_n;
        m_sprev = ps;
        m_dprev = pd;
    endtask

    task automatic chk(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // compare every observable output with the reference
    task automatic compare_all();
        int ps;
        ps = pend(m_swr, m_srd, m_ssize);
        chk(tag_of(reg_addr), int'(reg_rdata), model_rd(reg_addr));
        chk("R8", int'(irq_host), int'((m_ist & m_ie) != 0));
        chk("R11", int'(irq_err), int'((m_est & m_eie) != 0));
        chk("R13", int'(src_work), int'(ps != 0 && m_halted == 0));
        chk("R2", int'({dst_swap_en, src_swap_en, dst_max_len}), m_ctrl & 32'h3FFFF);
    endtask

    // drive one cycle, advance the reference, then compare at the falling edge
    task automatic tick(logic we, logic [7:0] a, logic [31:0] d,
                        logic sd, logic dd, logic busy, logic [3:0] ee);
        reg_we = we; reg_addr = a; reg_wdata = d;
        src_done = sd; dst_done = dd; xfer_busy = busy; err_evt = ee;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        tick(1'b1, a, d, 1'b0, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic idle(logic [7:0] a);
        tick(1'b0, a, 32'h0, 1'b0, 1'b0, 1'b0, 4'h0);
    endtask

    // watchdog: a hung run is a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int i = 0; i <= 8'h50; i += 4) idle(8'(i));
        chk("R1", int'(irq_host | irq_err | src_work), 0);

        // R2: control writable field
        wr(A_CTRL, 32'hFFFF_FFFF);
        idle(A_CTRL);
        chk("R2", int'(reg_rdata), 32'h0007_FFFF);
        chk("R2", int'(dst_max_len), 32'hFFFF);

        // R3: base alignment
        wr(A_SBASE, 32'h1234_5677);
        idle(A_SBASE);
        chk("R3", int'(reg_rdata), 32'h1234_5670);
        wr(A_DBASE, 32'hFFFF_FFFF);

        // ring setup
        wr(A_SSIZE, 8);
        wr(A_DSIZE, 4);
        wr(A_HEN, 32'h1F);
        wr(A_EEN, 32'h7E0);
        wr(A_SWM, 32'h0002_0004);
        wr(A_DWM, 32'h0001_0002);

        // R9: source high crossing
        wr(A_SWI, 5);
        idle(A_HST);
        chk("R9", int'(reg_rdata), 32'h2);

        // R6: overflow by one entry is rejected
        wr(A_SWI, 32'h0000_0100);
        idle(A_SWI);
        chk("R6", int'(reg_rdata), 5);
        idle(A_EST);
        chk("R6", int'(reg_rdata), 32'h20);
        chk("R11", int'(irq_err), 1);

        // R4/R9: drain four, low crossing and copy bit
        for (int i = 0; i < 4; i++) tick(1'b0, A_SRI, 0, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R4", int'(reg_rdata), 4);
        idle(A_HST);
        chk("R9", int'(reg_rdata), 32'h7);

        // R4: legal wrap-around write
        wr(A_SWI, 2);
        idle(A_SWI);
        chk("R4", int'(reg_rdata), 2);
        chk("R13", int'(src_work), 1);

        // R5: drain past empty
        for (int i = 0; i < 9; i++) tick(1'b0, A_SRI, 0, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R5", int'(reg_rdata), 2);
        chk("R13", int'(src_work), 0);

        // R10: clear races an event, the set wins
        wr(A_HST, 32'h1F);
        wr(A_SWI, 3);
        tick(1'b1, A_HST, 32'h1F, 1'b1, 1'b0, 1'b0, 4'h0);
        idle(A_HST);
        chk("R10", int'(reg_rdata[0]), 1);
        wr(A_HST, 32'h1F);
        idle(A_HST);
        chk("R10", int'(reg_rdata), 0);

        // R7: destination overflow
        wr(A_DWI, 3);
        wr(A_DWI, 0);
        idle(A_EST);
        chk("R7", int'(reg_rdata[6]), 1);
        tick(1'b0, A_DRI, 0, 1'b0, 1'b1, 1'b0, 4'h0);
        chk("R4", int'(reg_rdata), 1);

        // R4: read-index offsets ignore writes
        wr(A_DRI, 3);
        idle(A_DRI);
        chk("R4", int'(reg_rdata), 1);

        // R11: external error bits
        wr(A_EST, 32'h7E0);
        tick(1'b0, A_EST, 0, 1'b0, 1'b0, 1'b0, 4'hF);
        idle(A_EST);
        chk("R11", int'(reg_rdata), 32'h780);

        // R12/R13: halt waits for idle datapath
        wr(A_SWI, 7);
        tick(1'b1, A_CMD, 1, 1'b0, 1'b0, 1'b1, 4'h0);
        tick(1'b0, A_CMD, 0, 1'b0, 1'b0, 1'b1, 4'h0);
        tick(1'b0, A_CMD, 0, 1'b0, 1'b0, 1'b1, 4'h0);
        chk("R12", int'(reg_rdata), 1);
        tick(1'b0, A_CMD, 0, 1'b0, 1'b0, 1'b0, 4'h0);
        chk("R12", int'(reg_rdata), 9);
        tick(1'b0, A_SRI, 0, 1'b1, 1'b1, 1'b0, 4'h0);
        chk("R13", int'(reg_rdata), 3);
        chk("R13", int'(src_work), 0);
        wr(A_CMD, 0);
        idle(A_CMD);
        chk("R12", int'(reg_rdata), 0);

        // mixed traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int sel;
            sel = int'($urandom_range(0, 15));
            a = 8'(sel * 4);
            if (sel >= 5) a = a + 8'h18;
            if (sel == 5) a = A_CMD;
            d = $urandom;
            if (a == A_SSIZE || a == A_DSIZE) d = 32'(1) << $urandom_range(0, IDX_W);
            if (a == A_SWM || a == A_DWM) d = d & 32'h000F_000F;
            if (a == A_CMD) d = 32'($urandom_range(0, 3) == 0);
            tick(($urandom_range(0, 3) == 0), a, d, 1'($urandom), 1'($urandom),
                 1'($urandom), (($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule